// File: doc/BRIEF.md
# Macro Sequencer ALU with Carry and Bitfield Operations

This block is the arithmetic unit of a small macro sequencer. Each cycle it decodes one 32-bit instruction word and combines two operand values, A and B, taken from the sequencer's register file. It covers four kinds of work. The first is register-to-register arithmetic and logic, where the arithmetic can chain through a carry. The second is addition of a signed immediate. The third is three bitfield operations that move a masked field of B into place. The last is a read of a state register whose address is formed from A and the immediate.

The result is combinational. The block also holds the one-bit carry flag that the chained add and subtract operations read and update. The carry is written on a clock edge only when an instruction is issued and that instruction produces a carry. Fetch, write-back and branching are handled by the surrounding sequencer.

Top module: `macro_alu`

## Requirements
- R1: With instr[2:0]=1, result equals A plus the value of instr[31:14] sign-extended from 18 bits, modulo 2^32.
- R2: With instr[2:0]=0 and sub-operation instr[21:17]=0, result is A+B and the next carry is bit 32 of the unsigned sum. With sub-operation 1, the current carry flag is added as well.
- R3: With instr[2:0]=0 and sub-operation 2, result is A-B and the next carry is 1 exactly when A>=B unsigned. With sub-operation 3, an extra 1 is subtracted when the carry flag is 0, and the next carry is 1 when no borrow occurs.
- R4: With instr[2:0]=0, sub-operations 8 to 12 give, in that order: A xor B, A or B, A and B, A and not B, and not (A and B).
- R5: With instr[2:0]=2, B is shifted right logically by the source position instr[21:17] and masked to size instr[26:22] bits. That field of A at the destination position instr[31:27] is cleared, and the shifted B is inserted there.
- R6: With instr[2:0]=3, B is shifted right logically by A[4:0], masked to the size, then shifted left by the destination position.
- R7: With instr[2:0]=4, B is shifted right logically by the source position, masked to the size, then shifted left by A[4:0].
- R8: With instr[2:0]=5, the read address is A plus the sign-extended immediate, and result equals the read data.
- R9: The carry write enable is 1 only for sub-operations 0 to 3 of operation 0. The carry flag takes the next carry on a clock edge with issue high and the write enable high, and keeps its value otherwise.
- R10: Operations 6 and 7, and sub-operations of operation 0 other than 0 to 3 and 8 to 12, raise the illegal flag, give a result of 0 and do not write the carry.
- R11: During and after reset, the carry flag is 0.
- R12: A field size of 0 gives an empty mask. Extract operations then give 0, and a replace returns A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the carry flag |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction executes this cycle; allows the carry write |
| instr | input | 32 | Instruction word |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| readData | input | 32 | Value returned for readAddr |
| result | output | 32 | ALU result |
| carryNext | output | 1 | Carry value the current instruction would write |
| carryWe | output | 1 | Current instruction writes the carry |
| readAddr | output | 32 | State register address, A plus immediate |
| illegalOp | output | 1 | Undefined operation or sub-operation |
| carryFlag | output | 1 | Stored carry flag |

## Verification
On every cycle the assertions check the carry flag. It must hold when no carry write is issued, and it must take exactly the offered value when one is. They also check that only operation 0 raises the carry enable, that an illegal instruction gives zero with no carry write, and that the read operation passes the read data through. The arithmetic values can only be shown by the bench scenarios, since they need independently computed results. These values are the carry chaining through add and subtract with borrow, the bitfield shift and mask combinations including the size-0 and size-31 edges, and the sign extension of the immediate.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;
  localparam int DATA_W  = 32;
  localparam int SHIFT_W = $clog2(DATA_W);
  localparam int IMM_LSB = 14;
  localparam int IMM_W   = DATA_W - IMM_LSB;

  typedef enum logic [3:0] {
    K_ADD, K_ADC, K_SUB, K_SBB,
    K_XOR, K_OR, K_AND, K_ANDN, K_NAND,
    K_ADDI, K_BFREP, K_BFEXI, K_BFEXR, K_READ, K_ILL
  } aluKind_t;

  typedef struct packed {
    aluKind_t kind;
    logic     carryWrite;
    logic     illegal;
  } aluStrobe_t;
endpackage

// File: rtl/macro_alu_ctrl.sv
module macro_alu_ctrl
  import macro_alu_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  output aluStrobe_t        strobe
);
  logic [2:0] opSel;
  logic [4:0] subOp;

  assign opSel = instr[2:0];
  assign subOp = instr[21:17];

  always_comb begin
    strobe = '{kind: K_ILL, carryWrite: 1'b0, illegal: 1'b1};
    unique case (opSel)
      3'd0: begin
        strobe.illegal = 1'b0;
        case (subOp)
          5'd0:  begin strobe.kind = K_ADD; strobe.carryWrite = 1'b1; end
          5'd1:  begin strobe.kind = K_ADC; strobe.carryWrite = 1'b1; end
          5'd2:  begin strobe.kind = K_SUB; strobe.carryWrite = 1'b1; end
          5'd3:  begin strobe.kind = K_SBB; strobe.carryWrite = 1'b1; end
          5'd8:  strobe.kind = K_XOR;
          5'd9:  strobe.kind = K_OR;
          5'd10: strobe.kind = K_AND;
          5'd11: strobe.kind = K_ANDN;
          5'd12: strobe.kind = K_NAND;
          default: begin strobe.kind = K_ILL; strobe.illegal = 1'b1; end
        endcase
      end
      3'd1: begin strobe.kind = K_ADDI;  strobe.illegal = 1'b0; end
      3'd2: begin strobe.kind = K_BFREP; strobe.illegal = 1'b0; end
      3'd3: begin strobe.kind = K_BFEXI; strobe.illegal = 1'b0; end
      3'd4: begin strobe.kind = K_BFEXR; strobe.illegal = 1'b0; end
      3'd5: begin strobe.kind = K_READ;  strobe.illegal = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/macro_alu_dp.sv
module macro_alu_dp
  import macro_alu_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] readData,
  input  logic              carryIn,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic [DATA_W-1:0] readAddr
);
  logic [DATA_W-1:0]  immExt;
  logic [SHIFT_W-1:0] srcPos, fieldSize, dstPos, aShift;
  logic [DATA_W-1:0]  fieldMask;
  logic [DATA_W-1:0]  bAtSrc, bAtA;
  logic [DATA_W:0]    wideSum, wideDiff;
  logic               carryAdd, borrowSub;

  assign immExt    = {{(DATA_W-IMM_W){instr[DATA_W-1]}}, instr[DATA_W-1:IMM_LSB]};
  assign srcPos    = instr[21:17];
  assign fieldSize = instr[26:22];
  assign dstPos    = instr[31:27];
  assign aShift    = opA[SHIFT_W-1:0];
  assign fieldMask = (DATA_W'(1) << fieldSize) - DATA_W'(1);
  assign bAtSrc    = (opB >> srcPos) & fieldMask;
  assign bAtA      = (opB >> aShift) & fieldMask;
  assign readAddr  = opA + immExt;

  assign carryAdd  = (strobe.kind == K_ADC) && carryIn;
  assign borrowSub = (strobe.kind == K_SBB) && !carryIn;
  assign wideSum   = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryAdd};
  assign wideDiff  = {1'b0, opA} - {1'b0, opB} - {{DATA_W{1'b0}}, borrowSub};

  always_comb begin
    result   = '0;
    carryOut = carryIn;
    unique case (strobe.kind)
      K_ADD, K_ADC: begin result = wideSum[DATA_W-1:0];  carryOut = wideSum[DATA_W]; end
      K_SUB, K_SBB: begin result = wideDiff[DATA_W-1:0]; carryOut = !wideDiff[DATA_W]; end
      K_XOR:   result = opA ^ opB;
      K_OR:    result = opA | opB;
      K_AND:   result = opA & opB;
      K_ANDN:  result = opA & ~opB;
      K_NAND:  result = ~(opA & opB);
      K_ADDI:  result = readAddr;
      K_BFREP: result = (opA & ~(fieldMask << dstPos)) | (bAtSrc << dstPos);
      K_BFEXI: result = bAtA << dstPos;
      K_BFEXR: result = bAtSrc << aShift;
      K_READ:  result = readData;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issue,
  input  logic [31:0] instr,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] readData,
  output logic [31:0] result,
  output logic        carryNext,
  output logic        carryWe,
  output logic [31:0] readAddr,
  output logic        illegalOp,
  output logic        carryFlag
);
  aluStrobe_t strobe;

  macro_alu_ctrl u_ctrl (.instr(instr), .strobe(strobe));

  macro_alu_dp u_dp (
    .instr(instr), .opA(opA), .opB(opB), .readData(readData),
    .carryIn(carryFlag), .strobe(strobe),
    .result(result), .carryOut(carryNext), .readAddr(readAddr)
  );

  assign carryWe   = strobe.carryWrite;
  assign illegalOp = strobe.illegal;

  always_ff @(posedge clk) begin
    if (!rstN)                carryFlag <= 1'b0;
    else if (issue && carryWe) carryFlag <= carryNext;
  end
endmodule

// File: rtl/macro_alu_checker.sv
module macro_alu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        issue,
  input logic [31:0] instr,
  input logic [31:0] readData,
  input logic [31:0] result,
  input logic        carryNext,
  input logic        carryWe,
  input logic        illegalOp,
  input logic        carryFlag
);
  p_carry_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(issue && carryWe) |=> $stable(carryFlag));

  p_carry_take_r9: assert property (@(posedge clk) disable iff (!rstN)
    (issue && carryWe) |=> carryFlag == $past(carryNext));

  p_carry_only_op0_r9: assert property (@(posedge clk) disable iff (!rstN)
    carryWe |-> instr[2:0] == 3'd0);

  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (result == 32'h0 && !carryWe));

  p_illegal_op67_r10: assert property (@(posedge clk) disable iff (!rstN)
    (instr[2:1] == 2'b11) |-> illegalOp);

  p_read_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instr[2:0] == 3'd5) |-> result == readData);

  p_reset_clear_r11: assert property (@(posedge clk)
    !rstN |=> !carryFlag);
endmodule

bind macro_alu macro_alu_checker u_chk (
  .clk(clk), .rstN(rstN), .issue(issue), .instr(instr), .readData(readData),
  .result(result), .carryNext(carryNext), .carryWe(carryWe),
  .illegalOp(illegalOp), .carryFlag(carryFlag)
);

// File: tb/test_macro_alu.sv
module test_macro_alu;
  logic clk = 1'b0, rstN = 1'b0, issue = 1'b0;
  logic [31:0] instr = '0, opA = '0, opB = '0, readData = '0;
  logic [31:0] result, readAddr;
  logic carryNext, carryWe, illegalOp, carryFlag;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  macro_alu i_macro_alu (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] regOp(int sub);
    return 32'(sub) << 17;
  endfunction
  function automatic logic [31:0] immOp(int op, logic [17:0] imm);
    return ({imm, 14'b0}) | 32'(op);
  endfunction
  function automatic logic [31:0] bfOp(int op, int src, int size, int dst);
    return (32'(dst) << 27) | (32'(size) << 22) | (32'(src) << 17) | 32'(op);
  endfunction

  // Drive at negedge, let the comb settle, then optionally issue across a posedge.
  task automatic apply(logic [31:0] i, logic [31:0] a, logic [31:0] b, logic doIssue);
    @(negedge clk);
    instr = i; opA = a; opB = b; issue = doIssue;
    #1;
  endtask
  task automatic commit();
    @(posedge clk); #1; issue = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 carry after reset", {31'b0, carryFlag}, 32'h0);
  endtask

  task automatic t_add();
    apply(regOp(0), 32'hFFFF_FFFF, 32'h2, 1'b1);
    check("R2 add result", result, 32'h1);
    check("R2 add carry", {31'b0, carryNext}, 32'h1);
    check("R9 add we", {31'b0, carryWe}, 32'h1);
    commit();
    check("R9 carry stored", {31'b0, carryFlag}, 32'h1);
    apply(regOp(1), 32'h1, 32'h1, 1'b1);
    check("R2 adc with carry", result, 32'h3);
    commit();
    check("R2 adc carry out", {31'b0, carryFlag}, 32'h0);
    apply(regOp(1), 32'h1, 32'h1, 1'b1);
    check("R2 adc no carry", result, 32'h2);
    commit();
  endtask

  task automatic t_sub();
    apply(regOp(2), 32'h5, 32'h3, 1'b1);
    check("R3 sub result", result, 32'h2);
    check("R3 sub no borrow", {31'b0, carryNext}, 32'h1);
    commit();
    apply(regOp(2), 32'h3, 32'h5, 1'b1);
    check("R3 sub wrap", result, 32'hFFFF_FFFE);
    check("R3 sub borrow", {31'b0, carryNext}, 32'h0);
    commit();
    apply(regOp(3), 32'd10, 32'd3, 1'b1);
    check("R3 sbb borrow in", result, 32'd6);
    check("R3 sbb carry", {31'b0, carryNext}, 32'h1);
    commit();
    apply(regOp(3), 32'd3, 32'd3, 1'b1);
    check("R3 sbb carry set", result, 32'd0);
    check("R3 sbb equal carry", {31'b0, carryNext}, 32'h1);
    commit();
  endtask

  task automatic t_logic();
    logic [31:0] a = 32'hF0F0_00FF, b = 32'h0FF0_0F0F;
    apply(regOp(8), a, b, 1'b1);  check("R4 xor", result, 32'hFF00_0FF0);
    check("R9 logic no we", {31'b0, carryWe}, 32'h0);
    commit();
    check("R9 carry held", {31'b0, carryFlag}, 32'h1);
    apply(regOp(9), a, b, 1'b0);  check("R4 or", result, 32'hFFF0_0FFF);
    apply(regOp(10), a, b, 1'b0); check("R4 and", result, 32'h00F0_000F);
    apply(regOp(11), a, b, 1'b0); check("R4 andn", result, 32'hF000_00F0);
    apply(regOp(12), a, b, 1'b0); check("R4 nand", result, 32'hFF0F_FFF0);
  endtask

  task automatic t_imm();
    apply(immOp(1, 18'h3FFFC), 32'h100, 32'h0, 1'b0);
    check("R1 addi negative", result, 32'hFC);
    apply(immOp(1, 18'h1FFFF), 32'h0, 32'h0, 1'b0);
    check("R1 addi max positive", result, 32'h1FFFF);
    readData = 32'hCAFE;
    apply(immOp(5, 18'h20), 32'h10, 32'h0, 1'b0);
    check("R8 read addr", readAddr, 32'h30);
    check("R8 read result", result, 32'hCAFE);
  endtask

  task automatic t_bitfield();
    apply(bfOp(2, 4, 8, 16), 32'hFFFF_FFFF, 32'h0000_AB50, 1'b0);
    check("R5 replace", result, 32'hFFB5_FFFF);
    apply(bfOp(2, 0, 31, 0), 32'hFFFF_FFFF, 32'h0, 1'b0);
    check("R5 replace size31", result, 32'h8000_0000);
    apply(bfOp(3, 0, 4, 12), 32'h8, 32'h1234_5678, 1'b0);
    check("R6 extract imm", result, 32'h6000);
    apply(bfOp(3, 0, 4, 12), 32'h28, 32'h1234_5678, 1'b0);
    check("R6 low five bits of A", result, 32'h6000);
    apply(bfOp(4, 16, 8, 0), 32'h4, 32'h1234_5678, 1'b0);
    check("R7 extract reg", result, 32'h340);
    apply(bfOp(2, 3, 0, 5), 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0);
    check("R12 replace size0", result, 32'hDEAD_BEEF);
    apply(bfOp(4, 3, 0, 5), 32'h2, 32'hFFFF_FFFF, 1'b0);
    check("R12 extract size0", result, 32'h0);
  endtask

  task automatic t_illegal();
    logic c0;
    c0 = carryFlag;
    apply(32'h0000_0006 | regOp(1), 32'h5, 32'h5, 1'b1);
    check("R10 op6 flag", {31'b0, illegalOp}, 32'h1);
    check("R10 op6 zero", result, 32'h0);
    commit();
    apply(32'h7, 32'h5, 32'h5, 1'b0);
    check("R10 op7 flag", {31'b0, illegalOp}, 32'h1);
    apply(regOp(5), 32'hFFFF_FFFF, 32'h5, 1'b1);
    check("R10 sub5 zero", result, 32'h0);
    check("R10 sub5 no we", {31'b0, carryWe}, 32'h0);
    commit();
    apply(regOp(13), 32'h5, 32'h5, 1'b0);
    check("R10 sub13 flag", {31'b0, illegalOp}, 32'h1);
    check("R10 carry untouched", {31'b0, carryFlag}, {31'b0, c0});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_imm();
    t_bitfield();
    t_illegal();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule